// File: doc/BRIEF.md
# Iterative Radix-16 Integer Multiplier

This block is a sequential multiplier for the multiply group of a 32-bit integer execution unit. It accepts two raw operand words and a two-bit variant code. A small helper widens each operand by one bit, taking the operand's sign bit or a zero depending on the variant, so a single signed datapath covers the signed-by-signed, signed-by-unsigned and unsigned-by-unsigned cases. The full double-width product is formed from those widened operands. The multiplier operand is consumed one four-bit digit per clock. Its most significant digit is five bits wide and signed, so that the extension bit carries negative weight.

The handshake has three signals. A start pulse, sampled while the unit is idle, latches the operands and the variant. After the fixed number of iterations, the ready output rises and the selected half of the product appears on the result port. The result is held there until the consumer pulses the done input, which drops ready and returns the unit to idle. Further start requests made before then are discarded.

Top module: `iter_mul`

## Requirements
- R1: After reset, `res_ready` is low and `product` is zero.
- R2: The variant code `cmd` is 00 = low product, 01 = high signed×signed, 10 = high signed×unsigned, 11 = high unsigned×unsigned. Operand A is treated as signed for every code except 11. Operand B is treated as signed only for codes 00 and 01.
- R3: For code 00, `product` equals bits 31:0 of the product of the two widened operands.
- R4: For codes 01, 10 and 11, `product` equals bits 63:32 of the product of the two widened operands.
- R5: `res_ready` rises exactly 8 clock cycles after the rising edge at which `cmd_valid` was sampled high in the idle state.
- R6: While `res_ready` is low, `product` is zero.
- R7: While `res_ready` is high and `done_i` is low, `res_ready` stays high and `product` stays unchanged.
- R8: `done_i` sampled high while `res_ready` is high drives `res_ready` low on the next cycle and returns the unit to idle.
- R9: `cmd_valid` is ignored while an operation is running or its result is being held. The delivered result belongs to the accepted command, and no extra result follows it.
- R10: Operands and variant are captured at acceptance. Later changes on `src_a`, `src_b` and `cmd` do not affect the result.
- R11: `done_i` has no effect while `res_ready` is low. A pulse during an operation neither shortens nor cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Start request, sampled in idle |
| cmd | input | 2 | Multiply variant code |
| src_a | input | XLEN | Multiplicand word |
| src_b | input | XLEN | Multiplier word |
| done_i | input | 1 | Consumer has taken the result |
| res_ready | output | 1 | Result available |
| product | output | XLEN | Selected product half, zero when not ready |

## Verification
A wrong digit selection or a bad shift in the accumulator appears as a wrong result word at the first rise of ready. Operands with all ones or only the sign bit set expose a mishandled negative top digit, and only in the high-half variants. A control counter that is off by one moves the ready edge by a cycle, which the latency check catches on every command. A state machine that leaves the hold phase badly shows up as ready dropping without a done pulse, or as a second result appearing while start requests are kept asserted.

// File: rtl/imul_pkg.sv
package imul_pkg;
   typedef enum logic [1:0] {
      MC_LO    = 2'b00,
      MC_HI_SS = 2'b01,
      MC_HI_SU = 2'b10,
      MC_HI_UU = 2'b11
   } mul_cmd_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'b00,
      PH_RUN  = 2'b01,
      PH_HOLD = 2'b10
   } mul_phase_e;
endpackage

// File: rtl/imul_opext.sv
module imul_opext import imul_pkg::*; #(
   parameter int XLEN = 32,
   localparam int OPW = XLEN + 1
) (
   input  logic            valid,
   input  mul_cmd_e        cmd,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [OPW-1:0]  a_ext,
   output logic [OPW-1:0]  b_ext
);
   logic a_signed, b_signed;

   always_comb begin
      a_signed = (cmd != MC_HI_UU);
      b_signed = (cmd == MC_LO) || (cmd == MC_HI_SS);
      if (valid) begin
         a_ext = {a_signed & a[XLEN-1], a};
         b_ext = {b_signed & b[XLEN-1], b};
      end else begin
         a_ext = '0;
         b_ext = '0;
      end
   end
endmodule

// File: rtl/imul_ctrl.sv
module imul_ctrl import imul_pkg::*; #(
   parameter int ITER = 8,
   localparam int CW = (ITER > 1) ? $clog2(ITER) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic release_i,
   output logic load,
   output logic step,
   output logic last,
   output logic ready,
   output logic idle
);
   mul_phase_e      phase;
   logic [CW-1:0]   cnt;

   assign idle  = (phase == PH_IDLE);
   assign load  = idle && start;
   assign step  = (phase == PH_RUN);
   assign last  = step && (cnt == CW'(ITER - 1));
   assign ready = (phase == PH_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_RUN;
               cnt   <= '0;
            end
            PH_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == CW'(ITER - 1)) phase <= PH_HOLD;
            end
            PH_HOLD: if (release_i) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/imul_datapath.sv
module imul_datapath import imul_pkg::*; #(
   parameter int XLEN  = 32,
   parameter int DIGIT = 4,
   localparam int OPW  = XLEN + 1,
   localparam int HW   = OPW + DIGIT + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            step,
   input  logic            last,
   input  logic            ready,
   input  mul_cmd_e        cmd_in,
   input  logic [OPW-1:0]  a_ext,
   input  logic [OPW-1:0]  b_ext,
   output logic [XLEN-1:0] result
);
   logic signed [OPW-1:0] mcand;
   logic signed [HW-1:0]  acc_hi;
   logic [OPW-1:0]        acc_lo;
   mul_cmd_e              cmd_q;

   logic signed [DIGIT+1:0] digit_s;
   logic signed [HW-1:0]    mcand_w, digit_w, partial, sum;

   // Digit selection: plain unsigned digits, except the final one which
   // also takes the extension bit and carries negative weight.
   generate
      if (XLEN == DIGIT) begin : g_single_digit
         assign digit_s = $signed({acc_lo[DIGIT], acc_lo[DIGIT:0]});
      end else begin : g_multi_digit
         assign digit_s = last ? $signed({acc_lo[DIGIT], acc_lo[DIGIT:0]})
                               : $signed({2'b00, acc_lo[DIGIT-1:0]});
      end
   endgenerate

   always_comb begin
      mcand_w = HW'(mcand);
      digit_w = HW'(digit_s);
      partial = mcand_w * digit_w;
      sum     = acc_hi + partial;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand  <= '0;
         acc_hi <= '0;
         acc_lo <= '0;
         cmd_q  <= MC_LO;
      end else if (load) begin
         mcand  <= $signed(a_ext);
         acc_hi <= '0;
         acc_lo <= b_ext;
         cmd_q  <= cmd_in;
      end else if (step) begin
         acc_hi <= sum >>> DIGIT;
         acc_lo <= {sum[DIGIT-1:0], acc_lo[OPW-1:DIGIT]};
      end
   end

   always_comb begin
      if (!ready)               result = '0;
      else if (cmd_q == MC_LO)  result = acc_lo[OPW-1:1];
      else                      result = acc_hi[XLEN-1:0];
   end
endmodule

// File: rtl/iter_mul.sv
module iter_mul import imul_pkg::*; #(
   parameter int XLEN  = 32,
   parameter int DIGIT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [1:0]      cmd,
   input  logic [XLEN-1:0] src_a,
   input  logic [XLEN-1:0] src_b,
   input  logic            done_i,
   output logic            res_ready,
   output logic [XLEN-1:0] product
);
   localparam int ITER = XLEN / DIGIT;
   localparam int OPW  = XLEN + 1;

   generate
      if (DIGIT < 1 || XLEN % DIGIT != 0) begin : g_bad_digit
         $error("iter_mul: XLEN must be a multiple of DIGIT");
      end
   endgenerate

   logic           load, step, last, unit_idle;
   logic [OPW-1:0] a_ext, b_ext;
   mul_cmd_e       cmd_e;

   assign cmd_e = mul_cmd_e'(cmd);

   imul_opext #(.XLEN(XLEN)) u_opext (
      .valid (cmd_valid),
      .cmd   (cmd_e),
      .a     (src_a),
      .b     (src_b),
      .a_ext (a_ext),
      .b_ext (b_ext)
   );

   imul_ctrl #(.ITER(ITER)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_valid),
      .release_i (done_i),
      .load      (load),
      .step      (step),
      .last      (last),
      .ready     (res_ready),
      .idle      (unit_idle)
   );

   imul_datapath #(.XLEN(XLEN), .DIGIT(DIGIT)) u_dp (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .step   (step),
      .last   (last),
      .ready  (res_ready),
      .cmd_in (cmd_e),
      .a_ext  (a_ext),
      .b_ext  (b_ext),
      .result (product)
   );
endmodule

// File: rtl/iter_mul_chk.sv
module iter_mul_chk #(
   parameter int XLEN  = 32,
   parameter int DIGIT = 4,
   localparam int ITER = XLEN / DIGIT,
   localparam int LW   = $clog2(ITER + 2) + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic            done_i,
   input logic            unit_idle,
   input logic            res_ready,
   input logic [XLEN-1:0] product
);
   logic [LW-1:0] lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       lat <= '1;
      else if (unit_idle && cmd_valid)  lat <= '0;
      else if (lat != '1)               lat <= lat + 1'b1;
   end

   p_zero_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !res_ready |-> product == '0);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready && !done_i |=> res_ready && $stable(product));

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready && done_i |=> !res_ready && unit_idle);

   p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_ready) |-> lat == LW'(ITER));

   p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_idle && !res_ready |=> !$rose(unit_idle));
endmodule

bind iter_mul iter_mul_chk #(.XLEN(XLEN), .DIGIT(DIGIT)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .done_i    (done_i),
   .unit_idle (unit_idle),
   .res_ready (res_ready),
   .product   (product)
);

// File: tb/test_iter_mul.sv
module test_iter_mul;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd = 2'b00;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic        done_i = 1'b0;
   logic        res_ready;
   logic [31:0] product;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   iter_mul i_iter_mul (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
      .src_a(src_a), .src_b(src_b), .done_i(done_i),
      .res_ready(res_ready), .product(product)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R2: sign rules per code, R3/R4: half selection
   function automatic logic [31:0] ref_mul(input logic [1:0] c,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
      logic signed [65:0] ea, eb, p;
      bit as, bs;
      as = (c != 2'b11);
      bs = (c == 2'b00) || (c == 2'b01);
      ea = as ? 66'($signed(a)) : 66'(a);
      eb = bs ? 66'($signed(b)) : 66'(b);
      p  = ea * eb;
      return (c == 2'b00) ? p[31:0] : p[63:32];
   endfunction

   task automatic run_op(input logic [1:0] c, input logic [31:0] a,
                         input logic [31:0] b, input bit noisy);
      logic [31:0] exp;
      logic [31:0] held;
      int n;
      exp = ref_mul(c, a, b);
      @(negedge clk);
      cmd_valid = 1'b1; cmd = c; src_a = a; src_b = b;
      @(negedge clk);
      // R10: scramble inputs after capture
      cmd = ~c; src_a = $urandom; src_b = $urandom;
      cmd_valid = noisy;
      n = 0;
      while (!res_ready && n < 20) begin
         if (n == 2) chk(product == 32'd0, "R6 zero while busy", product, 32'd0);
         @(negedge clk);
         n++;
         if (noisy) begin
            src_a = $urandom; src_b = $urandom;
            done_i = (n == 3); // R11: done pulse mid-operation
         end
      end
      done_i = 1'b0;
      chk(n == 8, "R5 latency", 32'(n), 32'd8);
      chk(product == exp, (c == 2'b00) ? "R3 low product" : "R4 high product",
          product, exp);
      held = product;
      @(negedge clk);
      chk(res_ready && product == held, "R7 hold", product, held);
      done_i = 1'b1;
      @(negedge clk);
      done_i = 1'b0;
      cmd_valid = 1'b0;
      chk(!res_ready && product == 32'd0, "R8 release", {31'd0, res_ready}, 32'd0);
      if (noisy) begin
         repeat (10) @(negedge clk);
         chk(!res_ready, "R9 no extra result", {31'd0, res_ready}, 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [31:0] ext [5];
      ext[0] = 32'h0000_0000; ext[1] = 32'hFFFF_FFFF; ext[2] = 32'h8000_0000;
      ext[3] = 32'h7FFF_FFFF; ext[4] = 32'h0000_0001;
      #1;
      chk(!res_ready && product == 32'd0, "R1 reset state", product, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(!res_ready && product == 32'd0, "R1 after release", product, 32'd0);
      // R11: done while idle does nothing
      @(negedge clk); done_i = 1'b1;
      @(negedge clk); done_i = 1'b0;
      chk(!res_ready, "R11 done in idle", {31'd0, res_ready}, 32'd0);
      // R2: every variant on the extreme operand grid
      for (int c = 0; c < 4; c++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               run_op(2'(c), ext[i], ext[j], 1'b0);
      for (int k = 0; k < 200; k++)
         run_op(2'($urandom), $urandom, $urandom, 1'b0);
      // R9/R10/R11 with start requests held during busy and hold phases
      for (int k = 0; k < 24; k++)
         run_op(2'(k), $urandom, $urandom, 1'b1);
      run_op(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b1);
      run_op(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule